// File: doc/BRIEF.md
# Word-Serial Address-Event Burst Receiver

This block takes address-event bursts that arrive one word at a time and turns every column word into a single-cycle spike for one neuron of a pixel array. A burst opens when the burst request goes high. The address bus then holds a chip identifier. The next word, marked by a falling edge on the active-low word strobe, is the row. Every later strobed word is a column, and the burst closes when the request drops. Every word is acknowledged by toggling one acknowledge line.

Each pixel holds four neurons: an even-phase and an odd-phase filter output, each split into an ON and an OFF polarity. The least significant bit of the row word selects the phase. The least significant bit of the column word selects the polarity. A picture of R by C pixels is therefore addressed as a 2R by 2C neuron array. For each delivered spike, the block pulses one row select line and one column select line together. It also reports the pixel coordinates and the neuron type. An optional identifier filter suppresses delivery for bursts from other chips. Strobes that arrive outside a burst are flagged as protocol errors.

All inputs are taken to be synchronous to `clk`. Each output appears one clock after the edge that samples the word.

Top module: `aer_burst_rx`

## Requirements
- R1: While reset is applied and right after it, `ack` is 0 and `spk_valid`, `proto_err`, `row_sel` and `col_sel` are all zero.
- R2: `ack` changes value exactly once for every word received. The words are the chip word, taken when `burst_req` rises, and each strobed word, taken when `word_stb_n` falls. Stray strobes and words of filtered bursts are included. The change shows one clock after the sampling edge.
- R3: Within a burst, the first strobed word is taken as the row and produces no spike. Each later strobed word is a column and produces exactly one spike. A low `burst_req` closes the burst.
- R4: Bit 0 of the row word is the phase, with 0 for even and 1 for odd. It appears as `spk_type[1]`. `spk_prow` equals the row word shifted right by one.
- R5: Bit 0 of the column word is the polarity, with 0 for ON and 1 for OFF. It appears as `spk_type[0]`. `spk_pcol` equals the column word shifted right by one.
- R6: For each spike, exactly one bit of `row_sel` (index = row word) and exactly one bit of `col_sel` (index = column word) are high, in the same cycle as `spk_valid`, for one cycle. Both are all-zero otherwise.
- R7: The whole neuron array is reachable, including the last neuron at row word 2*PIX_ROWS-1 and column word 2*PIX_COLS-1 (63 and 127 by default).
- R8: A strobed word while no burst is open raises `proto_err` for one cycle and produces no spike. It is still acknowledged.
- R9: When `match_en` is 1, a burst whose chip word differs from `match_id` delivers no spikes, but all of its words are acknowledged. When `match_en` is 0, every burst delivers.
- R10: A column word whose strobe falls in the same cycle that `burst_req` falls is still delivered. The burst is closed afterwards, so the next strobe is a protocol error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| burst_req | input | 1 | High for the duration of a burst; rising edge marks the chip word |
| word_stb_n | input | 1 | Active-low word strobe; falling edge marks a row or column word |
| addr | input | ADDR_W | Word-serial address bus |
| match_en | input | 1 | Enables the chip identifier filter |
| match_id | input | ADDR_W | Chip identifier accepted when the filter is on |
| ack | output | 1 | Acknowledge, toggles once per word |
| spk_valid | output | 1 | One-cycle spike delivery pulse |
| spk_prow | output | $clog2(PIX_ROWS) | Pixel row of the spike |
| spk_pcol | output | $clog2(PIX_COLS) | Pixel column of the spike |
| spk_type | output | 2 | {phase, polarity} of the spiking neuron |
| row_sel | output | 2*PIX_ROWS | One-hot neuron row select strobe |
| col_sel | output | 2*PIX_COLS | One-hot neuron column select strobe |
| proto_err | output | 1 | One-cycle pulse for a strobe outside a burst |

## Verification
The closing of a burst and the delivery of its last column can fall in the same clock. This happens when the final strobe and the fall of the burst request are sampled on one edge. The bench provokes it by driving both changes at one falling clock edge. It judges the result by the scoreboard, which expects that column's spike, and by the acknowledge count. It then sends one more strobe, which must come back as a protocol error with no spike, proving that the burst really closed.

// File: rtl/aer_rx_pkg.sv
package aer_rx_pkg;

  // Position inside a word-serial burst
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // no burst open
    ST_ROW  = 2'd1,  // chip word taken, waiting for the row word
    ST_COL  = 2'd2   // row latched, column words follow
  } burst_st_t;

  // Neuron type codes {phase, polarity}
  localparam logic [1:0] NT_EVEN_ON  = 2'b00;
  localparam logic [1:0] NT_EVEN_OFF = 2'b01;
  localparam logic [1:0] NT_ODD_ON   = 2'b10;
  localparam logic [1:0] NT_ODD_OFF  = 2'b11;

endpackage

// File: rtl/aer_rx_framer.sv
module aer_rx_framer
  import aer_rx_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int ROW_AW = 6,
  parameter int COL_AW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_req,
  input  logic              word_stb_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              match_en,
  input  logic [ADDR_W-1:0] match_id,
  output logic              ack,
  output logic              spk_valid,
  output logic [ROW_AW-1:0] spk_row,
  output logic [COL_AW-1:0] spk_col,
  output logic              proto_err
);

  // input history for edge detection
  logic req_q, stb_q;
  logic burst_start, word_ev;

  burst_st_t         st_q, st_d;
  logic              chip_ok_q, chip_ok_d;
  logic [ROW_AW-1:0] row_q;
  logic              row_en;
  logic              ack_q, ack_d;
  logic              spk_v_q, spk_v_d;
  logic [ROW_AW-1:0] spk_row_q;
  logic [COL_AW-1:0] spk_col_q;
  logic              err_q, err_d;

  assign burst_start = burst_req & ~req_q;
  assign word_ev     = ~word_stb_n & stb_q;

  // next-state logic
  always_comb begin
    st_d      = st_q;
    chip_ok_d = chip_ok_q;
    row_en    = 1'b0;
    ack_d     = ack_q;
    spk_v_d   = 1'b0;
    err_d     = 1'b0;
    if (burst_start) begin
      st_d      = ST_ROW;
      chip_ok_d = !match_en || (addr == match_id);
      ack_d     = ~ack_q;
    end else if (word_ev) begin
      ack_d = ~ack_q;
      unique case (st_q)
        ST_ROW: begin
          row_en = 1'b1;
          st_d   = ST_COL;
        end
        ST_COL:  spk_v_d = chip_ok_q;
        default: err_d   = 1'b1;
      endcase
      if (!burst_req) st_d = ST_IDLE;
    end else if (!burst_req) begin
      st_d = ST_IDLE;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q     <= 1'b0;
      stb_q     <= 1'b1;
      st_q      <= ST_IDLE;
      chip_ok_q <= 1'b0;
      ack_q     <= 1'b0;
      spk_v_q   <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      req_q     <= burst_req;
      stb_q     <= word_stb_n;
      st_q      <= st_d;
      chip_ok_q <= chip_ok_d;
      ack_q     <= ack_d;
      spk_v_q   <= spk_v_d;
      err_q     <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
    end else if (row_en) begin
      row_q <= addr[ROW_AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spk_row_q <= '0;
      spk_col_q <= '0;
    end else if (spk_v_d) begin
      spk_row_q <= row_q;
      spk_col_q <= addr[COL_AW-1:0];
    end
  end

  assign ack       = ack_q;
  assign spk_valid = spk_v_q;
  assign spk_row   = spk_row_q;
  assign spk_col   = spk_col_q;
  assign proto_err = err_q;

  // R2
  ack_on_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(burst_start || word_ev) |-> (ack != $past(ack)));

  // R2
  ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(burst_start || word_ev) |-> $stable(ack));

  // R3
  spk_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spk_valid |-> $past(word_ev));

endmodule

// File: rtl/aer_rx_sel_decode.sv
module aer_rx_sel_decode #(
  parameter int N_ROWS = 64,
  parameter int N_COLS = 128,
  parameter int ROW_AW = 6,
  parameter int COL_AW = 7
) (
  input  logic              valid,
  input  logic [ROW_AW-1:0] row_addr,
  input  logic [COL_AW-1:0] col_addr,
  output logic [N_ROWS-1:0] row_sel,
  output logic [N_COLS-1:0] col_sel
);

  for (genvar gr = 0; gr < N_ROWS; gr++) begin : g_row
    assign row_sel[gr] = valid && (row_addr == ROW_AW'(gr));
  end

  for (genvar gc = 0; gc < N_COLS; gc++) begin : g_col
    assign col_sel[gc] = valid && (col_addr == COL_AW'(gc));
  end

endmodule

// File: rtl/aer_burst_rx.sv
module aer_burst_rx #(
  parameter int PIX_ROWS = 32,
  parameter int PIX_COLS = 64,
  parameter int ADDR_W   = 8,
  localparam int N_ROWS  = 2 * PIX_ROWS,
  localparam int N_COLS  = 2 * PIX_COLS,
  localparam int ROW_AW  = $clog2(N_ROWS),
  localparam int COL_AW  = $clog2(N_COLS),
  localparam int PR_W    = $clog2(PIX_ROWS),
  localparam int PC_W    = $clog2(PIX_COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_req,
  input  logic              word_stb_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              match_en,
  input  logic [ADDR_W-1:0] match_id,
  output logic              ack,
  output logic              spk_valid,
  output logic [PR_W-1:0]   spk_prow,
  output logic [PC_W-1:0]   spk_pcol,
  output logic [1:0]        spk_type,
  output logic [N_ROWS-1:0] row_sel,
  output logic [N_COLS-1:0] col_sel,
  output logic              proto_err
);

  // reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  logic [ROW_AW-1:0] nrn_row;
  logic [COL_AW-1:0] nrn_col;

  aer_rx_framer #(
    .ADDR_W (ADDR_W),
    .ROW_AW (ROW_AW),
    .COL_AW (COL_AW)
  ) u_framer (
    .clk        (clk),
    .rst_n      (rst_s2),
    .burst_req  (burst_req),
    .word_stb_n (word_stb_n),
    .addr       (addr),
    .match_en   (match_en),
    .match_id   (match_id),
    .ack        (ack),
    .spk_valid  (spk_valid),
    .spk_row    (nrn_row),
    .spk_col    (nrn_col),
    .proto_err  (proto_err)
  );

  aer_rx_sel_decode #(
    .N_ROWS (N_ROWS),
    .N_COLS (N_COLS),
    .ROW_AW (ROW_AW),
    .COL_AW (COL_AW)
  ) u_decode (
    .valid    (spk_valid),
    .row_addr (nrn_row),
    .col_addr (nrn_col),
    .row_sel  (row_sel),
    .col_sel  (col_sel)
  );

  assign spk_prow = nrn_row[ROW_AW-1:1];
  assign spk_pcol = nrn_col[COL_AW-1:1];
  assign spk_type = {nrn_row[0], nrn_col[0]};

  // R6
  sel_pair_chk: assert property (@(posedge clk) disable iff (!rst_s2)
    spk_valid |-> ($countones(row_sel) == 1) && ($countones(col_sel) == 1));

  // R6
  sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_s2)
    !spk_valid |-> (row_sel == '0) && (col_sel == '0));

  // R4
  phase_line_chk: assert property (@(posedge clk) disable iff (!rst_s2)
    spk_valid |-> row_sel[{spk_prow, spk_type[1]}]);

  // R8
  err_nospk_chk: assert property (@(posedge clk) disable iff (!rst_s2)
    proto_err |-> !spk_valid);

endmodule

// File: tb/aer_burst_rx_bench.sv
module aer_burst_rx_bench;

  localparam int PIX_ROWS = 32;
  localparam int PIX_COLS = 64;
  localparam int ADDR_W   = 8;
  localparam int N_ROWS   = 2 * PIX_ROWS;
  localparam int N_COLS   = 2 * PIX_COLS;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              burst_req;
  logic              word_stb_n;
  logic [ADDR_W-1:0] addr;
  logic              match_en;
  logic [ADDR_W-1:0] match_id;
  logic              ack;
  logic              spk_valid;
  logic [4:0]        spk_prow;
  logic [5:0]        spk_pcol;
  logic [1:0]        spk_type;
  logic [N_ROWS-1:0] row_sel;
  logic [N_COLS-1:0] col_sel;
  logic              proto_err;

  always #5 clk = ~clk;

  aer_burst_rx #(
    .PIX_ROWS (PIX_ROWS),
    .PIX_COLS (PIX_COLS),
    .ADDR_W   (ADDR_W)
  ) u_aer_burst_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .burst_req  (burst_req),
    .word_stb_n (word_stb_n),
    .addr       (addr),
    .match_en   (match_en),
    .match_id   (match_id),
    .ack        (ack),
    .spk_valid  (spk_valid),
    .spk_prow   (spk_prow),
    .spk_pcol   (spk_pcol),
    .spk_type   (spk_type),
    .row_sel    (row_sel),
    .col_sel    (col_sel),
    .proto_err  (proto_err)
  );

  typedef struct packed {
    logic [5:0] r;
    logic [6:0] c;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk    = 0;
  int   n_bad    = 0;
  int   exp_acks = 0;
  int   exp_errs = 0;
  int   err_seen = 0;
  int   spk_seen = 0;
  bit   done     = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as spikes appear
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (proto_err) err_seen++;
      if (spk_valid) begin
        spk_seen++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 spike with nothing expected", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(spk_prow == e.r[5:1], "R4 pixel row", int'(spk_prow), int'(e.r[5:1]));
          chk(spk_type[1] == e.r[0], "R4 phase bit", int'(spk_type[1]), int'(e.r[0]));
          chk(spk_pcol == e.c[6:1], "R5 pixel column", int'(spk_pcol), int'(e.c[6:1]));
          chk(spk_type[0] == e.c[0], "R5 polarity bit", int'(spk_type[0]), int'(e.c[0]));
          chk(row_sel[e.r] && $countones(row_sel) == 1, "R6 row select line",
              $countones(row_sel), 1);
          chk(col_sel[e.c] && $countones(col_sel) == 1, "R6 column select line",
              $countones(col_sel), 1);
        end
      end
    end
  end

  task automatic chip_word(input logic [7:0] id);
    @(negedge clk);
    addr      = id;
    burst_req = 1'b1;
    exp_acks++;
    @(negedge clk);
    chk(ack == exp_acks[0], "R2 ack after chip word", int'(ack), exp_acks % 2);
  endtask

  task automatic word(input logic [7:0] a);
    @(negedge clk);
    addr       = a;
    word_stb_n = 1'b0;
    exp_acks++;
    @(negedge clk);
    word_stb_n = 1'b1;
    chk(ack == exp_acks[0], "R2 ack after strobed word", int'(ack), exp_acks % 2);
  endtask

  task automatic col_word(input logic [5:0] r, input logic [6:0] c, input bit deliver);
    exp_t e;
    e.r = r;
    e.c = c;
    if (deliver) exp_q.push_back(e);
    word({1'b0, c});
  endtask

  task automatic end_burst();
    @(negedge clk);
    burst_req = 1'b0;
    @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 50000, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b0;
    burst_req  = 1'b0;
    word_stb_n = 1'b1;
    addr       = '0;
    match_en   = 1'b0;
    match_id   = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(ack == 1'b0, "R1 ack in reset", int'(ack), 0);
    chk(spk_valid == 1'b0 && proto_err == 1'b0, "R1 pulses in reset",
        int'(spk_valid) + int'(proto_err), 0);
    chk(row_sel == '0 && col_sel == '0, "R1 selects in reset",
        $countones(row_sel) + $countones(col_sel), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ack == 1'b0 && spk_valid == 1'b0 && proto_err == 1'b0, "R1 state after reset",
        int'(ack) + int'(spk_valid) + int'(proto_err), 0);

    // R3 R4 R5: even row, both polarities, filter off
    chip_word(8'd5);
    word(8'd0);                 // row word, no spike
    chk(spk_seen == 0, "R3 row word gives no spike", spk_seen, 0);
    col_word(6'd0, 7'd0, 1'b1); // even ON
    col_word(6'd0, 7'd1, 1'b1); // even OFF
    col_word(6'd0, 7'd10, 1'b1);
    end_burst();

    // R4 R5 R7: odd rows and the far corner
    chip_word(8'd9);
    word(8'd7);
    col_word(6'd7, 7'd127, 1'b1);
    col_word(6'd7, 7'd64, 1'b1);
    end_burst();
    chip_word(8'd0);
    word(8'd63);
    col_word(6'd63, 7'd126, 1'b1);
    col_word(6'd63, 7'd127, 1'b1);
    end_burst();
    chk(spk_seen == 7, "R7 spikes up to the corner", spk_seen, 7);

    // R8: stray strobe, no burst open
    word(8'd9);
    exp_errs++;
    @(negedge clk);
    chk(err_seen == exp_errs, "R8 stray strobe flagged", err_seen, exp_errs);
    chk(spk_seen == 7, "R8 stray strobe gives no spike", spk_seen, 7);

    // R9: filter on, foreign burst dropped but acknowledged
    match_en = 1'b1;
    match_id = 8'd3;
    chip_word(8'd4);
    word(8'd2);
    col_word(6'd2, 7'd5, 1'b0);
    col_word(6'd2, 7'd6, 1'b0);
    end_burst();
    chk(spk_seen == 7, "R9 foreign burst silent", spk_seen, 7);
    chip_word(8'd3);
    word(8'd2);
    col_word(6'd2, 7'd5, 1'b1);
    end_burst();
    chk(spk_seen == 8, "R9 matching burst delivers", spk_seen, 8);

    // R10: last column strobe together with request fall
    chip_word(8'd3);
    word(8'd12);
    col_word(6'd12, 7'd8, 1'b1);
    begin
      exp_t e;
      e.r = 6'd12;
      e.c = 7'd9;
      exp_q.push_back(e);
      @(negedge clk);
      addr       = 8'd9;
      word_stb_n = 1'b0;
      burst_req  = 1'b0;
      exp_acks++;
      @(negedge clk);
      word_stb_n = 1'b1;
      chk(ack == exp_acks[0], "R10 ack on closing word", int'(ack), exp_acks % 2);
    end
    @(negedge clk);
    chk(spk_seen == 10, "R10 closing column delivered", spk_seen, 10);
    word(8'd3);
    exp_errs++;
    @(negedge clk);
    chk(err_seen == exp_errs, "R10 burst closed after fall", err_seen, exp_errs);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R3 every expected spike seen", exp_q.size(), 0);
    chk(spk_seen == 10, "R3 spike total", spk_seen, 10);
    chk(err_seen == exp_errs, "R8 error total", err_seen, exp_errs);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule